// File: doc/BRIEF.md
# Programmable-Period PWM Timer

This block is an 8-bit up-counter that drives one pulse-width-modulated output. The period is not fixed at the full counter range. A period register sets the highest count, and the counter returns to zero on the tick after it reaches that value. A duty register sets where the output changes level within each period. A two-bit output mode selects one of three settings: a released pin, a normal-polarity waveform, or an inverted waveform. When the duty value is zero, or equal to the period value, the output holds a steady level.

Counting advances only on a count tick. The clock-select input chooses the source of that tick. The choices are every system clock, a fast-clock strobe (supplied by the caller as a pulse synchronous to the system clock), that strobe divided by powers of two, or no tick at all. The counter raises a wrap flag and a match flag. Each flag has an interrupt request gated by its own enable bit and by a global enable input. Software programs the block through a synchronous write port and a combinational read port. New period and duty values are staged and take effect only when the count wraps, so no period is ever cut short or stretched.

Top module: `pwm_prog_top_timer`

## Requirements
- R1: After reset: period register reads 0xFF, duty 0x00, control 0x00, count 0x00, flags 0x00, `pwm_oe` low, `pwm_o` low, both interrupt requests low.
- R2: On each count tick the count increments. When the count equals the active period value, the tick returns it to 0x00, so one period spans (period + 1) ticks.
- R3: Writes to duty (address 1) and period (address 2) read back at once, but the waveform and the wrap point use them only after the next wrap to 0x00.
- R4: In mode 2 (control bits [1:0] = 2), if the duty value D satisfies 0 < D < period, `pwm_o` is high while the count is below D and low otherwise. This gives D high ticks per period. `pwm_oe` is high.
- R5: In mode 3, `pwm_o` is the complement of the mode-2 waveform, and `pwm_oe` is high.
- R6: A duty of 0x00 gives a constant low in mode 2 and a constant high in mode 3. A duty equal to the period gives a constant high in mode 2 and a constant low in mode 3.
- R7: In modes 0 and 1, `pwm_oe` and `pwm_o` are low, while the counter keeps running and the flags are still set.
- R8: Flag bit 0 (address 4) is set on the tick that wraps the count to 0x00. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R9: Flag bit 1 is set on the tick whose new count equals the active duty value. It is cleared by writing 1 to that bit.
- R10: `ovf_irq` equals flag bit 0 AND control bit 2 AND `gie`. `cmp_irq` equals flag bit 1 AND control bit 3 AND `gie`.
- R11: `clk_sel` picks the tick source. 0 is no tick, 1 is every clock, 2 is every `fast_tick` pulse, 3/4/5 are every 2nd/4th/8th `fast_tick` pulse, and 6 and 7 are no tick.
- R12: The count (address 3) is read-only. Writes to it do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 3 | Tick source select |
| fast_tick | input | 1 | One-cycle strobe per fast peripheral clock edge |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pwm_o | output | 1 | PWM output level |
| pwm_oe | output | 1 | PWM output enable |
| ovf_irq | output | 1 | Wrap interrupt request |
| cmp_irq | output | 1 | Match interrupt request |

## Verification
If the active period or duty value is corrupted, the high-tick count of the very next period is wrong, and the count fails to return to zero exactly (period + 1) ticks after the previous wrap. The waveform is a combinational function of registered state, so a bad count value appears at `pwm_o` in the same cycle. Since the flags are single-stepped through the fast strobe, an event that is raised one tick early or late shows up within one step. A prescaler tap that is wrong changes the count advanced over eight strobes.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL  = 3'd0,
      REG_DUTY  = 3'd1,
      REG_TOP   = 3'd2,
      REG_COUNT = 3'd3,
      REG_FLAGS = 3'd4
   } reg_addr_e;

   // control field positions
   localparam int CTRL_MODE_LSB = 0;
   localparam int CTRL_OVF_IE   = 2;
   localparam int CTRL_CMP_IE   = 3;

   // flag positions
   localparam int FLAG_OVF = 0;
   localparam int FLAG_CMP = 1;

   typedef enum logic [1:0] {
      OM_OFF_A  = 2'd0,
      OM_OFF_B  = 2'd1,
      OM_NORMAL = 2'd2,
      OM_INVERT = 2'd3
   } out_mode_e;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
   parameter int DIV_STAGES = 3,
   localparam int NUM_SRC   = DIV_STAGES + 3,
   localparam int SEL_W     = $clog2(NUM_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             fast_tick,
   output logic             tick
);

   if (DIV_STAGES < 1) begin : g_bad_div
      $error("pwm_tick_gen: DIV_STAGES must be at least 1");
   end

   logic [DIV_STAGES-1:0] div_q;
   logic [NUM_SRC-1:0]    taps;

   // free-running divider of the fast strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         div_q <= '0;
      else if (fast_tick) div_q <= div_q + 1'b1;
   end

   assign taps[0] = 1'b0;
   assign taps[1] = 1'b1;
   assign taps[2] = fast_tick;

   for (genvar k = 1; k <= DIV_STAGES; k++) begin : g_tap
      assign taps[2+k] = fast_tick & (&div_q[k-1:0]);
   end

   always_comb begin
      if ({1'b0, sel} < (SEL_W+1)'(NUM_SRC)) tick = taps[sel];
      else                                   tick = 1'b0;
   end

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [DW-1:0] top_pend,
   input  logic [DW-1:0] cmp_pend,
   output logic [DW-1:0] cnt,
   output logic [DW-1:0] top_act,
   output logic [DW-1:0] cmp_act,
   output logic          wrap_evt,
   output logic          match_evt
);

   if (DW < 4) begin : g_bad_dw
      $error("pwm_count_core: DW must be at least 4");
   end

   logic          at_top;
   logic [DW-1:0] cnt_nxt;
   logic [DW-1:0] cmp_nxt;

   assign at_top    = (cnt == top_act);
   assign cnt_nxt   = at_top ? '0 : cnt + 1'b1;
   assign wrap_evt  = tick & at_top;
   assign cmp_nxt   = at_top ? cmp_pend : cmp_act;
   assign match_evt = tick & (cnt_nxt == cmp_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         top_act <= '1;
         cmp_act <= '0;
      end else if (tick) begin
         cnt <= cnt_nxt;
         if (at_top) begin
            top_act <= top_pend;
            cmp_act <= cmp_pend;
         end
      end
   end

   // R2
   cnt_le_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= top_act);

   // R2
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_top) |=> (cnt == '0));

   // R11
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   // R3
   top_load_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(top_act) |-> $past(wrap_evt));

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] cnt,
   input  logic [DW-1:0] top_act,
   input  logic [DW-1:0] cmp_act,
   input  logic [1:0]    mode,
   output logic          pwm_o,
   output logic          pwm_oe
);
   import pwm_timer_pkg::*;

   logic raw;

   always_comb begin
      if (cmp_act == top_act) raw = 1'b1;
      else                    raw = (cnt < cmp_act);
   end

   always_comb begin
      case (out_mode_e'(mode))
         OM_NORMAL: begin pwm_o = raw;  pwm_oe = 1'b1; end
         OM_INVERT: begin pwm_o = ~raw; pwm_oe = 1'b1; end
         default:   begin pwm_o = 1'b0; pwm_oe = 1'b0; end
      endcase
   end

endmodule

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank #(
   parameter int DW = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [pwm_timer_pkg::ADDR_W-1:0]    addr,
   input  logic [DW-1:0]                       wdata,
   output logic [DW-1:0]                       rdata,
   input  logic [DW-1:0]                       cnt,
   input  logic                                wrap_evt,
   input  logic                                match_evt,
   input  logic                                gie,
   output logic [1:0]                          mode,
   output logic [DW-1:0]                       top_pend,
   output logic [DW-1:0]                       cmp_pend,
   output logic                                ovf_irq,
   output logic                                cmp_irq
);
   import pwm_timer_pkg::*;

   logic ovf_ie, cmp_ie, ovf_flag, cmp_flag;
   logic wr_ctrl, wr_duty, wr_top, wr_flags;

   assign wr_ctrl  = wr_en & (addr == REG_CTRL);
   assign wr_duty  = wr_en & (addr == REG_DUTY);
   assign wr_top   = wr_en & (addr == REG_TOP);
   assign wr_flags = wr_en & (addr == REG_FLAGS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= 2'b00;
         ovf_ie   <= 1'b0;
         cmp_ie   <= 1'b0;
         top_pend <= '1;
         cmp_pend <= '0;
      end else begin
         if (wr_ctrl) begin
            mode   <= wdata[CTRL_MODE_LSB +: 2];
            ovf_ie <= wdata[CTRL_OVF_IE];
            cmp_ie <= wdata[CTRL_CMP_IE];
         end
         if (wr_duty) cmp_pend <= wdata;
         if (wr_top)  top_pend <= wdata;
      end
   end

   // event set wins over write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         cmp_flag <= 1'b0;
      end else begin
         ovf_flag <= (ovf_flag & ~(wr_flags & wdata[FLAG_OVF])) | wrap_evt;
         cmp_flag <= (cmp_flag & ~(wr_flags & wdata[FLAG_CMP])) | match_evt;
      end
   end

   assign ovf_irq = ovf_flag & ovf_ie & gie;
   assign cmp_irq = cmp_flag & cmp_ie & gie;

   always_comb begin
      case (addr)
         REG_CTRL:  rdata = DW'({cmp_ie, ovf_ie, mode});
         REG_DUTY:  rdata = cmp_pend;
         REG_TOP:   rdata = top_pend;
         REG_COUNT: rdata = cnt;
         REG_FLAGS: rdata = DW'({cmp_flag, ovf_flag});
         default:   rdata = '0;
      endcase
   end

   // R8
   ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(wrap_evt));

   // R10
   ovf_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> (ovf_flag && gie));

   // R9
   cmp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_flag) |-> $past(match_evt));

endmodule

// File: rtl/pwm_prog_top_timer.sv
module pwm_prog_top_timer #(
   parameter int DW         = 8,
   parameter int DIV_STAGES = 3,
   localparam int SEL_W     = $clog2(DIV_STAGES + 3)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [SEL_W-1:0]                 clk_sel,
   input  logic                             fast_tick,
   input  logic                             gie,
   input  logic                             wr_en,
   input  logic [pwm_timer_pkg::ADDR_W-1:0] addr,
   input  logic [DW-1:0]                    wdata,
   output logic [DW-1:0]                    rdata,
   output logic                             pwm_o,
   output logic                             pwm_oe,
   output logic                             ovf_irq,
   output logic                             cmp_irq
);

   logic          tick, wrap_evt, match_evt;
   logic [1:0]    mode;
   logic [DW-1:0] cnt, top_act, cmp_act, top_pend, cmp_pend;

   pwm_tick_gen #(.DIV_STAGES(DIV_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .sel(clk_sel), .fast_tick(fast_tick), .tick(tick)
   );

   pwm_count_core #(.DW(DW)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .top_pend(top_pend), .cmp_pend(cmp_pend),
      .cnt(cnt), .top_act(top_act), .cmp_act(cmp_act),
      .wrap_evt(wrap_evt), .match_evt(match_evt)
   );

   pwm_reg_bank #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .cnt(cnt),
      .wrap_evt(wrap_evt), .match_evt(match_evt), .gie(gie),
      .mode(mode), .top_pend(top_pend), .cmp_pend(cmp_pend),
      .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
   );

   pwm_wave_out #(.DW(DW)) u_wave (
      .cnt(cnt), .top_act(top_act), .cmp_act(cmp_act),
      .mode(mode), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
   );

   // R7
   released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe |-> !pwm_o);

endmodule

// File: tb/pwm_prog_top_timer_tb.sv
module pwm_prog_top_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] clk_sel = 3'd0;
   logic       fast_tick = 1'b0;
   logic       gie = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       pwm_o, pwm_oe, ovf_irq, cmp_irq;

   int n_run = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pwm_prog_top_timer u_dut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .fast_tick(fast_tick),
      .gie(gie), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .pwm_o(pwm_o), .pwm_oe(pwm_oe), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
   );

   typedef struct packed {
      logic [1:0] mode;
      logic [7:0] top;
      logic [7:0] cmp;
      logic [8:0] highs;
      logic       oe;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'd2, 8'd255, 8'd128, 9'd128, 1'b1},
      '{2'd2, 8'd9,   8'd3,   9'd3,   1'b1},
      '{2'd3, 8'd9,   8'd3,   9'd7,   1'b1},
      '{2'd2, 8'd9,   8'd0,   9'd0,   1'b1},
      '{2'd2, 8'd9,   8'd9,   9'd10,  1'b1},
      '{2'd3, 8'd9,   8'd0,   9'd10,  1'b1},
      '{2'd3, 8'd9,   8'd9,   9'd0,   1'b1},
      '{2'd0, 8'd5,   8'd2,   9'd0,   1'b0},
      '{2'd1, 8'd5,   8'd2,   9'd0,   1'b0},
      '{2'd3, 8'd200, 8'd50,  9'd151, 1'b1},
      '{2'd2, 8'd1,   8'd1,   9'd2,   1'b1},
      '{2'd2, 8'd9,   8'd3,   9'd3,   1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic step();
      @(negedge clk); fast_tick = 1'b1;
      @(negedge clk); fast_tick = 1'b0;
   endtask

   // wait for a wrap after a clear, then land on count 0
   task automatic sync_wrap();
      int v;
      int guard;
      wr(3'd4, 8'h03);
      guard = 0;
      rd(3'd4, v);
      while (!v[0] && guard < 1000) begin
         @(negedge clk); rd(3'd4, v); guard++;
      end
      rd(3'd3, v);
      while (v != 0 && guard < 2000) begin
         @(negedge clk); rd(3'd3, v); guard++;
      end
   endtask

   task automatic presc(input logic [2:0] s, input int adv, input string tag);
      int st, en;
      @(negedge clk);
      rd(3'd3, st);
      clk_sel = s; fast_tick = 1'b1;
      repeat (8) @(negedge clk);
      clk_sel = 3'd0; fast_tick = 1'b0;
      rd(3'd3, en);
      chk(tag, en, (st + adv) % 10);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++; n_run++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      int highs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(3'd2, v); chk("R1 top reset", v, 255);
      rd(3'd1, v); chk("R1 duty reset", v, 0);
      rd(3'd0, v); chk("R1 ctrl reset", v, 0);
      rd(3'd3, v); chk("R1 count reset", v, 0);
      rd(3'd4, v); chk("R1 flags reset", v, 0);
      chk("R1 oe reset", int'(pwm_oe), 0);
      chk("R1 pwm reset", int'(pwm_o), 0);
      chk("R1 irq reset", int'({ovf_irq, cmp_irq}), 0);

      // R12 count is read-only
      wr(3'd3, 8'h55);
      rd(3'd3, v); chk("R12 count write ignored", v, 0);

      // R3 staged duty/period
      wr(3'd0, 8'h02);
      wr(3'd1, 8'h80);
      wr(3'd2, 8'd9);
      rd(3'd1, v); chk("R3 duty readback", v, 128);
      rd(3'd2, v); chk("R3 top readback", v, 9);
      chk("R3 duty not yet active", int'(pwm_o), 0);
      @(negedge clk); clk_sel = 3'd1;
      repeat (10) @(negedge clk);
      clk_sel = 3'd0;
      rd(3'd3, v); chk("R3 old top still in use", v, 10);
      chk("R3 old duty still in use", int'(pwm_o), 0);

      // table of waveform vectors (R2 R4 R5 R6 R7)
      clk_sel = 3'd1;
      for (int i = 0; i < NV; i++) begin
         wr(3'd0, {6'd0, VECS[i].mode});
         wr(3'd1, VECS[i].cmp);
         wr(3'd2, VECS[i].top);
         sync_wrap();
         highs = 0;
         for (int t = 0; t <= int'(VECS[i].top); t++) begin
            highs += int'(pwm_o);
            if (t == 0) chk($sformatf("R4/R5/R7 oe vec %0d", i), int'(pwm_oe), int'(VECS[i].oe));
            @(negedge clk);
            #1;
         end
         chk($sformatf("R4/R5/R6 high ticks vec %0d", i), highs, int'(VECS[i].highs));
         rd(3'd3, v); chk($sformatf("R2 period vec %0d", i), v, 0);
         rd(3'd4, v); chk($sformatf("R7 flag set in mode vec %0d", i), v & 1, 1);
      end

      // single-step the counter (top 9, duty 3, mode 2)
      v = -1;
      while (v != 0) begin
         @(negedge clk); rd(3'd3, v);
      end
      clk_sel = 3'd2;
      wr(3'd4, 8'h03);
      step(); step();
      #1;
      rd(3'd4, v); chk("R9 no match before duty", v & 2, 0);
      chk("R4 high below duty", int'(pwm_o), 1);
      step();
      #1;
      rd(3'd4, v); chk("R9 match flag at duty", v & 2, 2);
      chk("R4 low at duty", int'(pwm_o), 0);
      repeat (6) step();
      #1;
      rd(3'd3, v); chk("R2 count at top", v, 9);
      rd(3'd4, v); chk("R8 no wrap flag before top", v & 1, 0);
      step();
      #1;
      rd(3'd3, v); chk("R2 wrap to zero", v, 0);
      rd(3'd4, v); chk("R8 wrap flag set", v & 1, 1);

      // R10 interrupt gating
      wr(3'd0, 8'h06);
      gie = 1'b0; #1;
      chk("R10 ovf irq no gie", int'(ovf_irq), 0);
      gie = 1'b1; #1;
      chk("R10 ovf irq on", int'(ovf_irq), 1);
      chk("R10 cmp irq disabled", int'(cmp_irq), 0);
      wr(3'd0, 8'h0E); #1;
      chk("R10 cmp irq on", int'(cmp_irq), 1);

      // R8 R9 write-one clear
      wr(3'd4, 8'h00);
      rd(3'd4, v); chk("R8 write zero keeps", v, 3);
      wr(3'd4, 8'h01);
      rd(3'd4, v); chk("R8 clear wrap flag", v, 2);
      chk("R10 ovf irq follows flag", int'(ovf_irq), 0);
      wr(3'd4, 8'h02);
      rd(3'd4, v); chk("R9 clear match flag", v, 0);

      // R11 tick sources (active top 9)
      presc(3'd1, 8, "R11 system clock");
      presc(3'd2, 8, "R11 fast strobe");
      presc(3'd3, 4, "R11 fast div2");
      presc(3'd4, 2, "R11 fast div4");
      presc(3'd5, 1, "R11 fast div8");
      presc(3'd6, 0, "R11 select 6 stops");
      presc(3'd0, 0, "R11 select 0 stops");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule